// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block runs one external transfer at a time on a bus of sixteen shared lines that carry both address and data, plus four upper lines that carry high address bits and then cycle status. The core asks for a transfer with a 20-bit address, a direction, a byte or word size, write data and a flag that marks the transfer as DMA-initiated. The block then moves through a fixed phase sequence: an address phase (T1), a turnaround phase (T2), a data phase (T3), any number of wait phases (TW) while the target holds the ready line low, and a closing phase (T4).

In T1 the full address is on the bus and a latch strobe is high, so an external latch can hold the address. After T1 the upper lines switch to status, and the shared lines either carry write data or are released so the target can drive read data. Read data is zero-extended into the returned word. The shared lines are modelled as separate output, output-enable and input vectors so that the pad tristate can sit outside the block.

A new request is taken whenever the block is idle or in T4. This allows back-to-back transfers with no idle cycle between them.

Top module: `addr_data_bus_seq`

## Requirements
- R1: After reset and while idle, `ale`, `ad_oe`, `done` and `busy` are low, `ad_out` and `hi_out` are zero, `req_ready` is high and `rd_data` is zero.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both high. In the next cycle (T1), `ale` and `ad_oe` are high, `ad_out` equals address bits 15..0 and `hi_out` equals address bits 19..16. The request inputs are captured at that edge and have no effect at any other time.
- R3: In T2, T3, every TW and T4, `hi_out[3]` equals the captured DMA flag (0 for a processor transfer, 1 for DMA) and `hi_out[2:0]` is 000.
- R4: T1, T2 and T3 each last one cycle. `bus_ready` is sampled at the end of T3 and at the end of each TW. A low sample inserts one TW, and a high sample moves on to T4.
- R5: On a write, `ad_oe` stays high from T1 through T4, and `ad_out` carries the data from T2 through T4. A word carries `req_wdata`. A byte to an even address carries {8'h00, wdata[7:0]}. A byte to an odd address carries {wdata[7:0], 8'h00}.
- R6: On a read, `ad_oe` is low and `ad_out` is zero from T2 through T4.
- R7: On a read, `rd_data` is loaded from `ad_in` at the edge that ends the last T3/TW, and is visible from T4 on. A word takes all of `ad_in`. An even byte returns {8'h00, ad_in[7:0]}. An odd byte returns {8'h00, ad_in[15:8]}. `rd_data` holds its value until the next read capture.
- R8: `done` is high for exactly the T4 cycle. `req_ready` is high when idle and in T4. A request taken in T4 starts T1 in the very next cycle.
- R9: In T1, `ad_out[0]` equals address bit 0. A low value marks a transfer that uses the lower data byte.
- R10: `busy` is high from T1 through T4 and low when idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Transfer request |
| req_addr | input | 20 | Transfer address |
| req_wdata | input | 16 | Write data |
| req_write | input | 1 | 1 = write, 0 = read |
| req_byte | input | 1 | 1 = byte transfer, 0 = word |
| req_dma | input | 1 | 1 = DMA-initiated transfer |
| req_ready | output | 1 | A request can be taken this cycle |
| bus_ready | input | 1 | Target ready, sampled at end of T3/TW |
| ad_in | input | 16 | Value seen on the shared lines |
| ad_out | output | 16 | Value driven onto the shared lines |
| ad_oe | output | 1 | Drive enable for the shared lines |
| hi_out | output | 4 | Upper address in T1, status afterwards |
| ale | output | 1 | Address latch strobe, high in T1 |
| rd_data | output | 16 | Captured read data |
| done | output | 1 | High in T4 |
| busy | output | 1 | A transfer is in progress |

## Verification
All outputs are decoded from flops, so each result appears in the cycle that follows the edge causing it:
- T1 is visible one cycle after the request edge.
- T4, `done` and new `rd_data` are visible one cycle after the edge that samples `bus_ready` high.

The bench keeps a behavioural phase model that it advances on each rising edge from the same inputs the design sees. It compares every output against that model at the falling edge, half a cycle after the outputs settle. Stimulus also changes only at falling edges, so request fields can be scrambled after they are taken and while a transfer is running. Together these let the bench catch any off-by-one in wait insertion or in capture timing.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_T1   = 3'd1,
    PH_T2   = 3'd2,
    PH_T3   = 3'd3,
    PH_TW   = 3'd4,
    PH_T4   = 3'd5
  } phase_e;
endpackage

// File: rtl/bus_phase_fsm.sv
module bus_phase_fsm
  import bus_seq_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   req_valid,
  input  logic   bus_ready,
  output phase_e ph,
  output logic   accept,
  output logic   capture
);
  phase_e ph_nxt;

  // A new transfer may start from idle or from the closing phase.
  assign accept  = req_valid && (ph == PH_IDLE || ph == PH_T4);
  assign capture = (ph == PH_T3 || ph == PH_TW) && bus_ready;

  always_comb begin
    ph_nxt = ph;
    unique case (ph)
      PH_IDLE: ph_nxt = accept ? PH_T1 : PH_IDLE;
      PH_T1:   ph_nxt = PH_T2;
      PH_T2:   ph_nxt = PH_T3;
      PH_T3,
      PH_TW:   ph_nxt = bus_ready ? PH_T4 : PH_TW;
      PH_T4:   ph_nxt = accept ? PH_T1 : PH_IDLE;
      default: ph_nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) ph <= PH_IDLE;
    else     ph <= ph_nxt;
  end
endmodule

// File: rtl/bus_lane_mux.sv
module bus_lane_mux
  import bus_seq_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int DATA_W  = 16,
  parameter int UPPER_W = ADDR_W - DATA_W
) (
  input  phase_e              ph,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  input  logic                is_write,
  input  logic                is_byte,
  input  logic                is_dma,
  output logic [DATA_W-1:0]   ad_out,
  output logic                ad_oe,
  output logic [UPPER_W-1:0]  hi_out,
  output logic                ale
);
  localparam int HALF = DATA_W / 2;

  logic              data_ph;
  logic [DATA_W-1:0] lane;

  assign data_ph = (ph == PH_T2) || (ph == PH_T3) || (ph == PH_TW) || (ph == PH_T4);

  // Steer a byte onto the half of the bus that matches address bit 0.
  always_comb begin
    if (!is_byte)     lane = wdata;
    else if (addr[0]) lane = {wdata[HALF-1:0], {HALF{1'b0}}};
    else              lane = {{HALF{1'b0}}, wdata[HALF-1:0]};
  end

  assign ale   = (ph == PH_T1);
  assign ad_oe = (ph == PH_T1) || (data_ph && is_write);

  always_comb begin
    if (ph == PH_T1)              ad_out = addr[DATA_W-1:0];
    else if (data_ph && is_write) ad_out = lane;
    else                          ad_out = '0;
  end

  always_comb begin
    if (ph == PH_T1)  hi_out = addr[ADDR_W-1:DATA_W];
    else if (data_ph) hi_out = {is_dma, {(UPPER_W-1){1'b0}}};
    else              hi_out = '0;
  end
endmodule

// File: rtl/bus_rd_capture.sv
module bus_rd_capture #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              is_byte,
  input  logic              odd,
  input  logic [DATA_W-1:0] ad_in,
  output logic [DATA_W-1:0] rd_data
);
  localparam int HALF = DATA_W / 2;

  logic [DATA_W-1:0] shaped;

  always_comb begin
    if (!is_byte) shaped = ad_in;
    else if (odd) shaped = {{HALF{1'b0}}, ad_in[DATA_W-1:HALF]};
    else          shaped = {{HALF{1'b0}}, ad_in[HALF-1:0]};
  end

  always_ff @(posedge clk) begin
    if (rst)       rd_data <= '0;
    else if (load) rd_data <= shaped;
  end
endmodule

// File: rtl/addr_data_bus_seq.sv
module addr_data_bus_seq
  import bus_seq_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int DATA_W  = 16,
  parameter int UPPER_W = ADDR_W - DATA_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  input  logic               req_write,
  input  logic               req_byte,
  input  logic               req_dma,
  output logic               req_ready,
  input  logic               bus_ready,
  input  logic [DATA_W-1:0]  ad_in,
  output logic [DATA_W-1:0]  ad_out,
  output logic               ad_oe,
  output logic [UPPER_W-1:0] hi_out,
  output logic               ale,
  output logic [DATA_W-1:0]  rd_data,
  output logic               done,
  output logic               busy
);
  phase_e             ph;
  logic               accept;
  logic               capture;
  logic [ADDR_W-1:0]  a_addr;
  logic [DATA_W-1:0]  a_wdata;
  logic               a_write;
  logic               a_byte;
  logic               a_dma;

  bus_phase_fsm u_fsm (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .bus_ready(bus_ready),
    .ph       (ph),
    .accept   (accept),
    .capture  (capture)
  );

  // Request fields are held for the whole transfer.
  always_ff @(posedge clk) begin
    if (rst) begin
      a_addr  <= '0;
      a_wdata <= '0;
      a_write <= 1'b0;
      a_byte  <= 1'b0;
      a_dma   <= 1'b0;
    end else if (accept) begin
      a_addr  <= req_addr;
      a_wdata <= req_wdata;
      a_write <= req_write;
      a_byte  <= req_byte;
      a_dma   <= req_dma;
    end
  end

  bus_lane_mux #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .UPPER_W(UPPER_W)
  ) u_mux (
    .ph      (ph),
    .addr    (a_addr),
    .wdata   (a_wdata),
    .is_write(a_write),
    .is_byte (a_byte),
    .is_dma  (a_dma),
    .ad_out  (ad_out),
    .ad_oe   (ad_oe),
    .hi_out  (hi_out),
    .ale     (ale)
  );

  bus_rd_capture #(.DATA_W(DATA_W)) u_cap (
    .clk    (clk),
    .rst    (rst),
    .load   (capture && !a_write),
    .is_byte(a_byte),
    .odd    (a_addr[0]),
    .ad_in  (ad_in),
    .rd_data(rd_data)
  );

  assign done      = (ph == PH_T4);
  assign busy      = (ph != PH_IDLE);
  assign req_ready = (ph == PH_IDLE) || (ph == PH_T4);
endmodule

// File: rtl/bus_seq_chk.sv
module bus_seq_chk
  import bus_seq_pkg::*;
#(
  parameter int UPPER_W = 4
) (
  input logic               clk,
  input logic               rst,
  input logic [2:0]         ph,
  input logic               a_write,
  input logic               ale,
  input logic               ad_oe,
  input logic [UPPER_W-1:0] hi_out,
  input logic               done,
  input logic               busy,
  input logic               req_valid
);
  logic data_ph;
  assign data_ph = (ph == PH_T2) || (ph == PH_T3) || (ph == PH_TW) || (ph == PH_T4);

  // R2
  ale_single_chk: assert property (@(posedge clk) disable iff (rst) ale |=> !ale);

  // R2
  ale_drives_chk: assert property (@(posedge clk) disable iff (rst) ale |-> ad_oe);

  // R3
  status_low_chk: assert property (@(posedge clk) disable iff (rst)
    data_ph |-> (hi_out[UPPER_W-2:0] == '0));

  // R4
  t2_to_t3_chk: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_T2) |=> (ph == PH_T3));

  // R6
  read_release_chk: assert property (@(posedge clk) disable iff (rst)
    (data_ph && !a_write) |-> !ad_oe);

  // R8
  done_once_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);

  // R8
  back_to_back_chk: assert property (@(posedge clk) disable iff (rst)
    (done && req_valid) |=> ale);

  // R10
  busy_ale_chk: assert property (@(posedge clk) disable iff (rst) ale |-> busy);
endmodule

bind addr_data_bus_seq bus_seq_chk #(.UPPER_W(UPPER_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .ph       (ph),
  .a_write  (a_write),
  .ale      (ale),
  .ad_oe    (ad_oe),
  .hi_out   (hi_out),
  .done     (done),
  .busy     (busy),
  .req_valid(req_valid)
);

// File: tb/addr_data_bus_seq_bench.sv
module addr_data_bus_seq_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [19:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        req_write = 1'b0;
  logic        req_byte = 1'b0;
  logic        req_dma = 1'b0;
  logic        req_ready;
  logic        bus_ready = 1'b1;
  logic [15:0] ad_in = '0;
  logic [15:0] ad_out;
  logic        ad_oe;
  logic [3:0]  hi_out;
  logic        ale;
  logic [15:0] rd_data;
  logic        done;
  logic        busy;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  addr_data_bus_seq u_addr_data_bus_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_write(req_write), .req_byte(req_byte),
    .req_dma(req_dma), .req_ready(req_ready), .bus_ready(bus_ready),
    .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe), .hi_out(hi_out),
    .ale(ale), .rd_data(rd_data), .done(done), .busy(busy)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural model: 0 idle, 1 T1, 2 T2, 3 T3, 4 wait, 5 T4
  int          mph = 0;
  logic [19:0] m_addr = '0;
  logic [15:0] m_wd = '0;
  logic        m_wr = 1'b0, m_by = 1'b0, m_dma = 1'b0;
  logic [15:0] m_rd = '0;

  always @(posedge clk) begin
    if (rst) begin
      mph = 0;
      m_rd = '0;
    end else begin
      case (mph)
        0, 5: begin
          if (req_valid) begin
            m_addr = req_addr; m_wd = req_wdata; m_wr = req_write;
            m_by = req_byte; m_dma = req_dma; mph = 1;
          end else mph = 0;
        end
        1: mph = 2;
        2: mph = 3;
        3, 4: begin
          if (bus_ready) begin
            if (!m_wr) begin
              if (!m_by)         m_rd = ad_in;
              else if (m_addr[0]) m_rd = {8'h00, ad_in[15:8]};
              else               m_rd = {8'h00, ad_in[7:0]};
            end
            mph = 5;
          end else mph = 4;
        end
        default: mph = 0;
      endcase
    end
  end

  bit running = 1'b0;

  always @(negedge clk) begin
    if (running && !rst) begin
      logic [15:0] e_ad;
      logic [3:0]  e_hi;
      logic        e_oe;
      string       t_ad;
      if (mph == 0) begin
        e_ad = '0; e_hi = '0; e_oe = 1'b0; t_ad = "R1";
      end else if (mph == 1) begin
        e_ad = m_addr[15:0]; e_hi = m_addr[19:16]; e_oe = 1'b1; t_ad = "R2";
      end else begin
        e_hi = {m_dma, 3'b000};
        e_oe = m_wr;
        t_ad = m_wr ? "R5" : "R6";
        if (!m_wr)          e_ad = '0;
        else if (!m_by)     e_ad = m_wd;
        else if (m_addr[0]) e_ad = {m_wd[7:0], 8'h00};
        else                e_ad = {8'h00, m_wd[7:0]};
      end
      chk(ale == (mph == 1), "R2 ale", 32'(ale), 32'(mph == 1));
      chk(hi_out == e_hi, (mph == 1) ? "R2 hi_out" : "R3 hi_out", 32'(hi_out), 32'(e_hi));
      chk(ad_out == e_ad, t_ad, 32'(ad_out), 32'(e_ad));
      chk(ad_oe == e_oe, t_ad, 32'(ad_oe), 32'(e_oe));
      if (mph == 1) chk(ad_out[0] == m_addr[0], "R9 addr bit0", 32'(ad_out[0]), 32'(m_addr[0]));
      chk(done == (mph == 5), "R4 done timing", 32'(done), 32'(mph == 5));
      chk(req_ready == (mph == 0 || mph == 5), "R8 req_ready", 32'(req_ready),
          32'(mph == 0 || mph == 5));
      chk(busy == (mph != 0), "R10 busy", 32'(busy), 32'(mph != 0));
      chk(rd_data == m_rd, "R7 rd_data", 32'(rd_data), 32'(m_rd));
    end
  end

  // Called at a falling edge; returns at the falling edge inside T4.
  task automatic run(input logic [19:0] a, input logic [15:0] wd, input bit wr,
                     input bit by, input bit dma, input logic [15:0] din,
                     input int nwait, input bit nag);
    req_valid = 1'b1; req_addr = a; req_wdata = wd; req_write = wr;
    req_byte = by; req_dma = dma; ad_in = din;
    @(negedge clk);
    req_valid = 1'b0; req_addr = ~a; req_wdata = ~wd; req_write = ~wr;
    req_byte = ~by; req_dma = ~dma;
    @(negedge clk);
    if (nag) req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k <= nwait; k++) begin
      bus_ready = (k == nwait);
      @(negedge clk);
    end
    bus_ready = 1'b1;
  endtask

  task automatic idle(input int n);
    req_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R4 watchdog act=%h exp=%h", 32'd1, 32'd0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state while reset is held
    chk(!ale && !ad_oe && !done && !busy && req_ready && rd_data == 0 &&
        ad_out == 0 && hi_out == 0, "R1 reset state",
        {ale, ad_oe, done, busy, req_ready}, 32'b00001);
    rst = 1'b0;
    running = 1'b1;
    idle(2);
    run(20'hA5F32, 16'hBEEF, 1'b1, 1'b0, 1'b0, 16'h0000, 0, 1'b0);
    idle(1);
    run(20'h12345, 16'h77C3, 1'b1, 1'b1, 1'b1, 16'h0000, 2, 1'b0);
    run(20'hF0010, 16'h1155, 1'b1, 1'b1, 1'b0, 16'h0000, 0, 1'b0);
    run(20'h30000, 16'h0000, 1'b0, 1'b0, 1'b0, 16'hCAFE, 1, 1'b1);
    idle(2);
    run(20'h80101, 16'h0000, 1'b0, 1'b1, 1'b1, 16'hA1B2, 3, 1'b0);
    run(20'h40FFE, 16'h0000, 1'b0, 1'b1, 1'b0, 16'h5566, 0, 1'b1);
    idle(1);
    // R7: read result stays after the transfer
    chk(rd_data == 16'h0066, "R7 held byte", 32'(rd_data), 32'h0066);
    idle(3);
    running = 1'b0;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule